// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command bus of a four-bank synchronous DRAM from reset until the memory is ready for ordinary traffic. It first keeps the bus at NOP for a programmable number of clock cycles, which covers the power-up settling time. It then sends one precharge to all banks and a configurable number of auto-refresh commands, never fewer than two. It also sends one load-mode-register command that carries the mode word presented on `mode_i`. Between commands it inserts NOP gaps that cover the precharge, refresh and mode-load recovery times. When the last gap has run out, it raises a done flag that stays high until the next reset.

By default the refreshes come before the mode load. A build-time parameter moves them after it. Every output is registered on the rising clock edge, so the memory samples clean values. The wait and the gaps are given in clock cycles; the integrator derives them from the clock frequency. The read and write path, periodic refresh and the data bus are handled by logic outside this block.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_ni` is low, the bus shows NOP ({cs,ras,cas,we} = 0111), `addr_o` and `ba_o` are zero and `done_o` is low. Asserting reset at any point of the sequence restarts it from the beginning.
- R2: After reset is released, the first `WAIT_CYC` registered outputs, one per rising edge, are NOP.
- R3: The first command other than NOP appears on edge `WAIT_CYC`+1. It is a precharge (0010) with `addr_o[10]` high to cover all banks and `ba_o` zero.
- R4: Exactly `N_REF` auto-refresh commands (0001) are issued, and `N_REF` is at least two.
- R5: Exactly one load-mode command (0000) is issued. Its `addr_o` equals the `mode_i` value present in the cycle before it appears, and its `ba_o` is zero.
- R6: With `REF_AFTER_MODE`=0 the order is precharge, refreshes, mode load. With `REF_AFTER_MODE`=1 it is precharge, mode load, refreshes.
- R7: After a precharge exactly `T_RP` NOP cycles follow, after each refresh exactly `T_RC`, and after the mode load exactly `T_MRD`, before the next command.
- R8: `done_o` rises one cycle after the gap of the last command has expired and then stays high, with the bus at NOP, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | ADDR_W | Mode word placed on the address bus by the mode-load command |
| cs_n_o | output | 1 | Chip select strobe, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write-enable strobe, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | High once initialization has completed |

## Verification
The bench builds two instances. The first has a 20-cycle wait, three refreshes, refreshes before the mode load, and gaps of 2/3/2. The second has a 13-cycle wait, two refreshes, refreshes after the mode load, and gaps of 1/4/3. Because the waits are short, each sweep compares every cycle of both complete sequences, from reset through several cycles past `done_o`, against a timeline the bench computes. This covers both command orders, the minimum refresh count and every gap length. A reset applied in the middle of the first sweep is followed by a second full sweep, which shows that the sequence restarts cleanly.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_GAP  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/init_step_sel.sv
module init_step_sel
  import sdram_init_pkg::*;
#(
  parameter int N_REF          = 2,
  parameter bit REF_AFTER_MODE = 1'b0,
  parameter int T_RP           = 2,
  parameter int T_RC           = 7,
  parameter int T_MRD          = 2,
  parameter int IDX_W          = 3,
  parameter int CNT_W          = 8
) (
  input  logic [IDX_W-1:0] idx_i,
  output cmd_e             kind_o,
  output logic [CNT_W-1:0] gap_o
);
  localparam int N_STEPS = N_REF + 2;

  cmd_e kind;

  generate
    if (REF_AFTER_MODE) begin : g_ref_late
      always_comb begin
        if (idx_i == '0)                 kind = CMD_PRE;
        else if (idx_i == IDX_W'(1))     kind = CMD_MRS;
        else                             kind = CMD_REF;
      end
    end else begin : g_ref_early
      always_comb begin
        if (idx_i == '0)                         kind = CMD_PRE;
        else if (idx_i == IDX_W'(N_STEPS - 1))   kind = CMD_MRS;
        else                                     kind = CMD_REF;
      end
    end
  endgenerate

  always_comb begin
    unique case (kind)
      CMD_PRE: gap_o = CNT_W'(T_RP);
      CMD_REF: gap_o = CNT_W'(T_RC);
      CMD_MRS: gap_o = CNT_W'(T_MRD);
      default: gap_o = '0;
    endcase
  end

  assign kind_o = kind;
endmodule

// File: rtl/init_ctrl.sv
module init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int WAIT_CYC = 20000,
  parameter int N_REF    = 2,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             kind_i,
  input  logic [CNT_W-1:0] gap_i,
  output logic [IDX_W-1:0] idx_o,
  output cmd_e             cmd_d_o,
  output logic             done_d_o
);
  localparam int N_STEPS = N_REF + 2;

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    cmd_d_o  = CMD_NOP;
    done_d_o = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        if (cnt_q == '0) begin
          cmd_d_o = kind_i;
          cnt_d   = gap_i;
          idx_d   = idx_q + IDX_W'(1);
          st_d    = ST_GAP;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_GAP: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (idx_q == IDX_W'(N_STEPS)) begin
          st_d     = ST_DONE;
          done_d_o = 1'b1;
        end else begin
          cmd_d_o = kind_i;
          cnt_d   = gap_i;
          idx_d   = idx_q + IDX_W'(1);
        end
      end
      default: done_d_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_WAIT;
      cnt_q <= CNT_W'(WAIT_CYC);
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign idx_o = idx_q;

  // R4: step index never runs past the last command
  a_r4_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= IDX_W'(N_STEPS));

  // R3: the step chosen at the end of the wait is the precharge
  a_r3_first_is_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && cnt_q == '0) |-> kind_i == CMD_PRE);

  // R8: completion is terminal
  a_r8_done_terminal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DONE |=> st_q == ST_DONE);
endmodule

// File: rtl/cmd_out_reg.sv
module cmd_out_reg
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int MIN_GAP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_d_i,
  input  logic              done_d_i,
  input  logic [ADDR_W-1:0] mode_i,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              done_o
);
  localparam int ALL_BANK_BIT = 10;

  cmd_e              cmd_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BA_W-1:0]   ba_q;
  logic              done_q;

  always_comb begin
    addr_d = '0;
    unique case (cmd_d_i)
      CMD_PRE: addr_d[ALL_BANK_BIT] = 1'b1;
      CMD_MRS: addr_d = mode_i;
      default: addr_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d_i;
      addr_q <= addr_d;
      ba_q   <= '0;
      done_q <= done_d_i;
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign ba_o   = ba_q;
  assign done_o = done_q;

  a_r3_pre_all_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_PRE |-> addr_q[ALL_BANK_BIT] && ba_q == '0);

  a_r5_mode_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q == CMD_MRS |-> addr_q == $past(mode_i));

  a_r7_gap_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MIN_GAP > 0 && cmd_q != CMD_NOP) |=> cmd_q == CMD_NOP);

  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  a_r8_quiet_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cmd_q == CMD_NOP);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W         = 12,
  parameter int BA_W           = 2,
  parameter int WAIT_CYC       = 20000,
  parameter int N_REF          = 2,
  parameter bit REF_AFTER_MODE = 1'b0,
  parameter int T_RP           = 3,
  parameter int T_RC           = 9,
  parameter int T_MRD          = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int N_STEPS = N_REF + 2;
  localparam int IDX_W   = $clog2(N_STEPS + 1);
  localparam int MAX_GAP = max_int(max_int(T_RP, T_RC), T_MRD);
  localparam int MIN_GAP = (T_RP < T_RC) ? ((T_RP < T_MRD) ? T_RP : T_MRD)
                                         : ((T_RC < T_MRD) ? T_RC : T_MRD);
  localparam int CNT_W   = $clog2(max_int(WAIT_CYC, MAX_GAP) + 1);

  logic [IDX_W-1:0] idx;
  cmd_e             kind, cmd_d, cmd_q;
  logic [CNT_W-1:0] gap;
  logic             done_d;

  init_step_sel #(
    .N_REF(N_REF), .REF_AFTER_MODE(REF_AFTER_MODE),
    .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_step_sel (
    .idx_i (idx),
    .kind_o(kind),
    .gap_o (gap)
  );

  init_ctrl #(
    .WAIT_CYC(WAIT_CYC), .N_REF(N_REF), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kind_i  (kind),
    .gap_i   (gap),
    .idx_o   (idx),
    .cmd_d_o (cmd_d),
    .done_d_o(done_d)
  );

  cmd_out_reg #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .MIN_GAP(MIN_GAP)
  ) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_d_i (cmd_d),
    .done_d_i(done_d),
    .mode_i  (mode_i),
    .cmd_o   (cmd_q),
    .addr_o  (addr_o),
    .ba_o    (ba_o),
    .done_o  (done_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  localparam int A_W = 20, A_RP = 2, A_RC = 3, A_MRD = 2, A_NREF = 3;
  localparam int B_W = 13, B_RP = 1, B_RC = 4, B_MRD = 3, B_NREF = 2;
  localparam logic [11:0] A_MODE = 12'h5A3, B_MODE = 12'h033;
  localparam int SWEEP = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  logic        a_cs, a_ras, a_cas, a_we, a_done;
  logic [1:0]  a_ba;
  logic [11:0] a_addr;
  logic        b_cs, b_ras, b_cas, b_we, b_done;
  logic [1:0]  b_ba;
  logic [11:0] b_addr;

  sdram_init_seq #(
    .WAIT_CYC(A_W), .N_REF(A_NREF), .REF_AFTER_MODE(1'b0),
    .T_RP(A_RP), .T_RC(A_RC), .T_MRD(A_MRD)
  ) i_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(A_MODE),
    .cs_n_o(a_cs), .ras_n_o(a_ras), .cas_n_o(a_cas), .we_n_o(a_we),
    .ba_o(a_ba), .addr_o(a_addr), .done_o(a_done)
  );

  sdram_init_seq #(
    .WAIT_CYC(B_W), .N_REF(B_NREF), .REF_AFTER_MODE(1'b1),
    .T_RP(B_RP), .T_RC(B_RC), .T_MRD(B_MRD)
  ) i_sdram_init_seq_alt (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(B_MODE),
    .cs_n_o(b_cs), .ras_n_o(b_ras), .cas_n_o(b_cas), .we_n_o(b_we),
    .ba_o(b_ba), .addr_o(b_addr), .done_o(b_done)
  );

  // Expected output after rising edge n (n >= 1) following reset release.
  task automatic expect_at(input int n, input int w, input int rp, input int rc,
                           input int mrd, input int nref, input bit after,
                           output logic [3:0] cmd, output bit done, output string tag);
    int pos;
    logic [3:0] k;
    int g;
    cmd = NOP; done = 1'b0;
    if (n <= w) begin tag = "R2"; return; end
    pos = w + 1;
    for (int s = 0; s < nref + 2; s++) begin
      if (s == 0) k = PRE;
      else if (after) k = (s == 1) ? MRS : REF;
      else k = (s == nref + 1) ? MRS : REF;
      g = (k == PRE) ? rp : (k == REF) ? rc : mrd;
      if (n == pos) begin
        cmd = k;
        tag = (k == PRE) ? "R3" : (k == MRS) ? "R5" : (after ? "R6" : "R4");
        return;
      end
      if (n < pos + 1 + g) begin tag = "R7"; return; end
      pos = pos + 1 + g;
    end
    done = 1'b1; tag = "R8";
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_reset_state();
    check("R1", "a cmd in reset", {a_cs, a_ras, a_cas, a_we}, NOP);
    check("R1", "a addr/ba in reset", {a_ba, a_addr}, 0);
    check("R1", "a done in reset", a_done, 0);
    check("R1", "b cmd in reset", {b_cs, b_ras, b_cas, b_we}, NOP);
    check("R1", "b addr/ba in reset", {b_ba, b_addr}, 0);
    check("R1", "b done in reset", b_done, 0);
  endtask

  task automatic check_cycle(input int n);
    logic [3:0] ec;
    bit ed;
    string tg;
    logic [11:0] ea;
    expect_at(n, A_W, A_RP, A_RC, A_MRD, A_NREF, 1'b0, ec, ed, tg);
    ea = (ec == PRE) ? 12'h400 : (ec == MRS) ? A_MODE : 12'h000;
    check(tg, $sformatf("a cmd @%0d", n), {a_cs, a_ras, a_cas, a_we}, ec);
    check(tg, $sformatf("a addr @%0d", n), a_addr, ea);
    check(tg, $sformatf("a ba @%0d", n), a_ba, 0);
    check("R8", $sformatf("a done @%0d", n), a_done, ed);
    expect_at(n, B_W, B_RP, B_RC, B_MRD, B_NREF, 1'b1, ec, ed, tg);
    ea = (ec == PRE) ? 12'h400 : (ec == MRS) ? B_MODE : 12'h000;
    check(tg, $sformatf("b cmd @%0d", n), {b_cs, b_ras, b_cas, b_we}, ec);
    check(tg, $sformatf("b addr @%0d", n), b_addr, ea);
    check(tg, $sformatf("b ba @%0d", n), b_ba, 0);
    check("R8", $sformatf("b done @%0d", n), b_done, ed);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check_reset_state();          // R1
    rst_n = 1'b1;
    // partial run, then reset mid-sequence (R1 restart)
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      check_cycle(n);
    end
    rst_n = 1'b0;
    #1;
    check_reset_state();          // R1 asynchronous clear
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    for (int n = 1; n <= SWEEP; n++) begin
      @(negedge clk);
      check_cycle(n);
    end
    // R8: done holds over a long idle stretch
    repeat (100) @(negedge clk);
    check("R8", "a done held", a_done, 1);
    check("R8", "b done held", b_done, 1);
    check("R8", "a bus idle", {a_cs, a_ras, a_cas, a_we}, NOP);
    check("R8", "b bus idle", {b_cs, b_ras, b_cas, b_we}, NOP);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule